// File: doc/BRIEF.md
# SCL Period Generator

This block produces the clock line waveform for an I2C master. It alternates between a low phase, during which it asks the pad to pull SCL down, and a high phase, during which it lets the line go. Each phase lasts a programmed number of counts, and each count is one or two system clock cycles, as the prescale select chooses. A byte engine next to it uses two single-cycle strobes to know when the clock has just been released and when the next low phase has just begun.

The low count runs from the first cycle the block pulls the line down; it does not wait to see the line fall. The high count advances only on cycles where the sampled SCL input reads high. Slow rise times and clock stretching by a target therefore lengthen the released interval but never shorten the time the line is seen high. Each count is nine bits wide: eight bits come from their own register and the ninth from a separate configuration bit. A parameter removes that ninth bit on variants that lack it, which limits the count to 255. Count values and the prescale choice are captured when a phase begins, so they can be rewritten at any time without disturbing the phase in progress.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and while `enable` is low, `sclDriveLow`, `riseStrobe` and `fallStrobe` are all 0.
- R2: The low phase (`sclDriveLow`=1) lasts exactly N*D cycles whatever `sclIn` does. N is the effective low count and D is the number of cycles per count. It begins on the cycle after `enable` is sampled high from idle, and on the cycle after a high phase ends.
- R3: The low count is {`lowCountHi`, `lowCount[7:0]`}: `lowCountHi` is count bit 8 (weight 256).
- R4: During the high phase, only cycles with `sclIn`=1 are counted. The phase ends after N*D such cycles, and cycles with `sclIn`=0 (rise time, stretching) hold the count.
- R5: The high count is {`highCountHi`, `highCount[7:0]`}: `highCountHi` is count bit 8 (weight 256).
- R6: `prescaleSel`=0 gives D=1 system clock per count; `prescaleSel`=1 gives D=2.
- R7: A count value of 0 behaves as 1.
- R8: `riseStrobe` is high for exactly the first cycle of each high phase (first released cycle). `fallStrobe` is high for exactly the first cycle of each low phase that follows a high phase. The two never coincide, and neither fires on the first low phase after idle.
- R9: When `enable` is sampled low, the next cycle has SCL released and no strobes. Re-enabling starts a full-length low phase.
- R10: The counts and `prescaleSel` are captured when each phase starts. A change in mid-phase takes effect from the next phase of that kind.
- R11: With parameter `EXT_EN`=0 the bit-8 inputs are ignored and counts are limited to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when high |
| lowCount | input | BASE_W | Low-phase count, bits 7..0 |
| lowCountHi | input | 1 | Low-phase count bit 8 |
| highCount | input | BASE_W | High-phase count, bits 7..0 |
| highCountHi | input | 1 | High-phase count bit 8 |
| prescaleSel | input | 1 | 0: one clock per count, 1: two clocks per count |
| sclIn | input | 1 | Synchronised sample of the SCL line |
| sclDriveLow | output | 1 | Request to pull SCL low |
| riseStrobe | output | 1 | First cycle after SCL is released |
| fallStrobe | output | 1 | First cycle of a low phase that ends a high phase |

## Verification
The generator is first run with small counts and an SCL that rises at once, which pins the basic phase lengths. It is then run with a delayed rise and with a long stretch; these separate counting from release and counting from the observed high level. The prescale run, the nine-bit counts and the zero counts each set one dimension of the count arithmetic on its own. Disabling in mid-phase and rewriting a count during a low phase show whether values are captured per phase or read live.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic loadLow;
    logic loadHigh;
    logic advance;
  } cnt_cmd_t;

endpackage

// File: rtl/scl_period_dp.sv
module scl_period_dp
  import scl_gen_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cnt_cmd_t          cmd,
  input  logic [BASE_W-1:0] lowCount,
  input  logic              lowCountHi,
  input  logic [BASE_W-1:0] highCount,
  input  logic              highCountHi,
  input  logic              prescaleSel,
  output logic              atLast
);
  localparam int CNT_W = BASE_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lowFull, highFull, lowEff, highEff;
  logic [CNT_W-1:0] limit, cnt;
  logic             sub, subLast;

  generate
    if (EXT_EN) begin : g_ext
      assign lowFull  = {lowCountHi, lowCount};
      assign highFull = {highCountHi, highCount};
    end else begin : g_noext
      assign lowFull  = {1'b0, lowCount};
      assign highFull = {1'b0, highCount};
    end
  endgenerate

  // a zero count behaves as one
  assign lowEff  = (lowFull == '0)  ? ONE : lowFull;
  assign highEff = (highFull == '0) ? ONE : highFull;

  assign atLast = (sub == subLast) && (cnt == limit - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limit   <= '0;
      cnt     <= '0;
      sub     <= 1'b0;
      subLast <= 1'b0;
    end else if (cmd.clear) begin
      cnt <= '0;
      sub <= 1'b0;
    end else if (cmd.loadLow) begin
      limit   <= lowEff;
      subLast <= prescaleSel;
      cnt     <= '0;
      sub     <= 1'b0;
    end else if (cmd.loadHigh) begin
      limit   <= highEff;
      subLast <= prescaleSel;
      cnt     <= '0;
      sub     <= 1'b0;
    end else if (cmd.advance) begin
      if (sub == subLast) begin
        sub <= 1'b0;
        cnt <= cnt + ONE;
      end else begin
        sub <= 1'b1;
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limit != '0) |-> (cnt < limit));

  // R6
  sub_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sub == 1'b0) || (subLast == 1'b1));

endmodule

// File: rtl/scl_period_ctrl.sv
module scl_period_ctrl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     sclIn,
  input  logic     atLast,
  output cnt_cmd_t cmd,
  output logic     sclDriveLow,
  output logic     riseStrobe,
  output logic     fallStrobe
);
  phase_e phase, phaseNext;
  logic   riseNext, fallNext;

  always_comb begin
    cmd       = '0;
    phaseNext = phase;
    riseNext  = 1'b0;
    fallNext  = 1'b0;
    if (!enable) begin
      phaseNext = PH_IDLE;
      cmd.clear = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext   = PH_LOW;
          cmd.loadLow = 1'b1;
        end
        PH_LOW: begin
          cmd.advance = 1'b1;
          if (atLast) begin
            phaseNext    = PH_HIGH;
            cmd.loadHigh = 1'b1;
            riseNext     = 1'b1;
          end
        end
        PH_HIGH: begin
          cmd.advance = sclIn;
          if (sclIn && atLast) begin
            phaseNext   = PH_LOW;
            cmd.loadLow = 1'b1;
            fallNext    = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      riseStrobe <= 1'b0;
      fallStrobe <= 1'b0;
    end else begin
      phase      <= phaseNext;
      riseStrobe <= riseNext;
      fallStrobe <= fallNext;
    end
  end

  assign sclDriveLow = (phase == PH_LOW);

  // R9
  disable_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !riseStrobe && !fallStrobe));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStrobe, fallStrobe}));

  // R8
  rise_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (!sclDriveLow && $past(sclDriveLow)));

  // R8
  fall_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> sclDriveLow);

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |=> !riseStrobe);

  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && enable && !sclIn) |=> (phase == PH_HIGH));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [BASE_W-1:0] lowCount,
  input  logic              lowCountHi,
  input  logic [BASE_W-1:0] highCount,
  input  logic              highCountHi,
  input  logic              prescaleSel,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              riseStrobe,
  output logic              fallStrobe
);
  cnt_cmd_t cmd;
  logic     atLast;

  scl_period_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .atLast     (atLast),
    .cmd        (cmd),
    .sclDriveLow(sclDriveLow),
    .riseStrobe (riseStrobe),
    .fallStrobe (fallStrobe)
  );

  scl_period_dp #(
    .BASE_W(BASE_W),
    .EXT_EN(EXT_EN)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .lowCount   (lowCount),
    .lowCountHi (lowCountHi),
    .highCount  (highCount),
    .highCountHi(highCountHi),
    .prescaleSel(prescaleSel),
    .atLast     (atLast)
  );

endmodule

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
  localparam int BASE_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, enable, prescaleSel, sclIn;
  logic [BASE_W-1:0] lowCount, highCount;
  logic lowCountHi, highCountHi;
  logic drv, rise, fall;
  logic nxDrv, nxRise, nxFall;

  scl_period_gen #(.BASE_W(BASE_W), .EXT_EN(1'b1)) i_scl_period_gen (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lowCount(lowCount), .lowCountHi(lowCountHi),
    .highCount(highCount), .highCountHi(highCountHi),
    .prescaleSel(prescaleSel), .sclIn(sclIn),
    .sclDriveLow(drv), .riseStrobe(rise), .fallStrobe(fall));

  scl_period_gen #(.BASE_W(BASE_W), .EXT_EN(1'b0)) i_scl_period_gen_noext (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lowCount(lowCount), .lowCountHi(lowCountHi),
    .highCount(highCount), .highCountHi(highCountHi),
    .prescaleSel(prescaleSel), .sclIn(sclIn),
    .sclDriveLow(nxDrv), .riseStrobe(nxRise), .fallStrobe(nxFall));

  int checks = 0, fails = 0;
  string curReq = "R2";
  int riseDelay = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 low, 2 high
  int mState = 0, mLeft = 0;
  bit mRise = 0, mFall = 0;

  function automatic int effCount(input int base, input bit hi, input bit ext);
    int v;
    v = base + ((hi && ext) ? 256 : 0);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    mRise = 0;
    mFall = 0;
    if (!rstN || !enable) begin
      mState = 0;
      mLeft  = 0;
    end else begin
      case (mState)
        0: begin
          mState = 1;
          mLeft  = effCount(lowCount, lowCountHi, 1) * (prescaleSel ? 2 : 1);
        end
        1: begin
          mLeft--;
          if (mLeft == 0) begin
            mState = 2;
            mLeft  = effCount(highCount, highCountHi, 1) * (prescaleSel ? 2 : 1);
            mRise  = 1;
          end
        end
        default: begin
          if (sclIn) begin
            mLeft--;
            if (mLeft == 0) begin
              mState = 1;
              mLeft  = effCount(lowCount, lowCountHi, 1) * (prescaleSel ? 2 : 1);
              mFall  = 1;
            end
          end
        end
      endcase
    end
  end

  // line model, measurements and per-cycle comparison
  int relCnt = 0, lowRun = 0, lastLow = 0, lowEnds = 0;
  int hiCnt = 0, relRun = 0, lastHigh = 0, lastRel = 0, highEnds = 0;
  int nxRun = 0, nxLast = -1;
  bit prevDrv = 0, inHigh = 0, nxPrev = 0;

  initial sclIn = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      chk(drv == (mState == 1), curReq, drv, (mState == 1));
      chk(rise == mRise, "R8 rise", rise, mRise);
      chk(fall == mFall, "R8 fall", fall, mFall);
    end
    if (drv) begin
      relCnt = 0;
      sclIn  = 1'b0;
    end else begin
      relCnt++;
      sclIn = (relCnt > riseDelay);
    end
    if (drv) lowRun++;
    else if (prevDrv) begin
      lastLow = lowRun;
      lowRun  = 0;
      lowEnds++;
    end
    if (rise) inHigh = 1;
    if (inHigh && !drv) begin
      if (sclIn) hiCnt++;
      relRun++;
    end
    if (inHigh && drv) begin
      lastHigh = hiCnt;
      lastRel  = relRun;
      hiCnt    = 0;
      relRun   = 0;
      inHigh   = 0;
      highEnds++;
    end
    if (!enable) begin
      inHigh = 0;
      hiCnt  = 0;
      relRun = 0;
      lowRun = 0;
      nxRun  = 0;
    end
    if (nxDrv) nxRun++;
    else if (nxPrev) nxLast = nxRun;
    nxPrev  = nxDrv;
    prevDrv = drv;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitLowEnds(input int n);
    int target;
    target = lowEnds + n;
    while (lowEnds < target) @(negedge clk);
    #1;
  endtask

  task automatic waitHighEnds(input int n);
    int target;
    target = highEnds + n;
    while (highEnds < target) @(negedge clk);
    #1;
  endtask

  task automatic waitDriveLow();
    @(negedge clk);
    while (!drv) @(negedge clk);
    #1;
  endtask

  task automatic setup(input int lo, input bit loHi, input int hi, input bit hiHi,
                       input bit ps, input int rd);
    enable = 1'b0;
    cyc(2);
    lowCount = BASE_W'(lo);
    lowCountHi = loHi;
    highCount = BASE_W'(hi);
    highCountHi = hiHi;
    prescaleSel = ps;
    riseDelay = rd;
    cyc(1);
    enable = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    enable = 1'b0;
    lowCount = 8'd3;
    lowCountHi = 1'b0;
    highCount = 8'd2;
    highCountHi = 1'b0;
    prescaleSel = 1'b0;
    cyc(3);
    // R1: reset state
    chk(drv == 1'b0 && rise == 1'b0 && fall == 1'b0, "R1 reset", {drv, rise, fall}, 0);
    rstN = 1'b1;
    cyc(3);
    chk(drv == 1'b0, "R1 disabled", drv, 0);

    // R2 R4: basic phases, immediate rise
    curReq = "R2 basic";
    enable = 1'b1;
    waitLowEnds(3);
    chk(lastLow == 3, "R2 low length", lastLow, 3);
    waitHighEnds(1);
    chk(lastHigh == 2, "R4 high count", lastHigh, 2);
    chk(lastRel == 2, "R4 released length", lastRel, 2);

    // R4: slow rise excluded from the high count
    curReq = "R4 rise delay";
    riseDelay = 3;
    waitHighEnds(2);
    chk(lastHigh == 2, "R4 high count with rise delay", lastHigh, 2);
    chk(lastRel == 5, "R4 released length with rise delay", lastRel, 5);
    chk(lastLow == 3, "R2 low unaffected by rise delay", lastLow, 3);

    // R9: disable in mid low phase
    curReq = "R9 disable";
    waitDriveLow();
    enable = 1'b0;
    cyc(1);
    chk(drv == 1'b0, "R9 release next cycle", drv, 0);
    cyc(3);
    chk(drv == 1'b0 && rise == 1'b0 && fall == 1'b0, "R9 stays idle", {drv, rise, fall}, 0);

    // R6 R9: prescale 2, restart with full low phase
    curReq = "R6 prescale";
    setup(4, 0, 3, 0, 1, 0);
    waitLowEnds(1);
    chk(lastLow == 8, "R6 R9 low length with prescale", lastLow, 8);
    waitHighEnds(1);
    chk(lastHigh == 6, "R6 high count with prescale", lastHigh, 6);

    // R3 R5 R11: ninth bit
    curReq = "R3 R5 ext";
    setup(2, 1, 1, 1, 0, 0);
    waitLowEnds(1);
    chk(lastLow == 258, "R3 low bit 8", lastLow, 258);
    chk(nxLast == 2, "R11 bit 8 ignored without extension", nxLast, 2);
    waitHighEnds(1);
    chk(lastHigh == 257, "R5 high bit 8", lastHigh, 257);

    // R7: zero counts
    curReq = "R7 zero";
    setup(0, 0, 0, 0, 0, 0);
    waitLowEnds(2);
    chk(lastLow == 1, "R7 zero low count", lastLow, 1);
    waitHighEnds(1);
    chk(lastHigh == 1, "R7 zero high count", lastHigh, 1);

    // R4: long stretch
    curReq = "R4 stretch";
    setup(2, 0, 3, 0, 0, 10);
    waitHighEnds(2);
    chk(lastHigh == 3, "R4 high count under stretch", lastHigh, 3);
    chk(lastRel == 13, "R4 released length under stretch", lastRel, 13);

    // R10: mid-phase change of the low count
    curReq = "R10 capture";
    setup(6, 0, 2, 0, 0, 0);
    waitDriveLow();
    cyc(2);
    lowCount = 8'd2;
    waitLowEnds(1);
    chk(lastLow == 6, "R10 current low phase keeps old count", lastLow, 6);
    waitLowEnds(1);
    chk(lastLow == 2, "R10 next low phase uses new count", lastLow, 2);

    enable = 1'b0;
    cyc(3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule